// File: doc/BRIEF.md
# Parallel Tree Reduction Engine

The engine collapses up to `LANES` partial sums, held side by side in a register array, into one total. After a start pulse it runs a halving tree. In each round, every lane that is still active adds a partner element into its own element, and all of those additions happen at once. The round count therefore grows with the logarithm of the lane count, not linearly. Each round completes in one clock, and the clock edge acts as the barrier between rounds. When the active count is odd, lane 0 also absorbs the trailing element of that round, so any lane count from 1 to `LANES` is reduced correctly.

A request can optionally begin with a local phase. In that phase each lane first accumulates its own contiguous slice of `SLICE` elements from the input vector, one element per clock, before the tree starts. Without the local phase, each lane takes only the first element of its slice. When the total is ready, the engine raises a one-cycle completion pulse. The total stays on the result port until the next accepted start.

Top module: `tree_reduce_engine`

## Requirements
- R1: While reset is high and on the cycle after it, busy_o and done_o are 0 and sum_o is 0.
- R2: With local_en_i low at start, lane i starts from input element i*SLICE, where element k occupies din_i bits [k*DW +: DW]. The final sum_o is the sum of those values over lanes 0..N-1.
- R3: With local_en_i high at start, lane i starts from the sum of elements i*SLICE through i*SLICE+SLICE-1. This phase costs SLICE-1 extra clocks.
- R4: count_i sets the active lane count N. Any N from 1 to LANES is reduced correctly, odd or even. A count of 0 acts as 1, and a count above LANES acts as LANES.
- R5: done_o rises exactly L + floor(log2 N) + 1 rising edges after the edge that samples start. L is SLICE-1 in local mode and 0 otherwise.
- R6: done_o is high for exactly one cycle per request.
- R7: A start that arrives while busy_o is high is ignored. The result and the timing of the request in flight are unchanged.
- R8: All sums wrap modulo 2^DW, and no overflow is reported.
- R9: After done_o, sum_o holds its value until the next accepted start, even if din_i changes.
- R10: busy_o is high from the edge that samples start up to the edge that raises done_o, and it is low while done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Starts a reduction when the engine is idle |
| local_en_i | input | 1 | Selects the per-lane slice accumulation phase |
| count_i | input | $clog2(LANES+1) | Requested active lane count N |
| din_i | input | LANES*SLICE*DW | Input element vector; element k is at bits k*DW +: DW |
| busy_o | output | 1 | A reduction is in progress |
| done_o | output | 1 | One-cycle pulse: sum_o holds the total |
| sum_o | output | DW | Element 0 of the lane array, which holds the total after done |

## Verification
The bench drives odd active counts (3, 5, 7, 9), because a design that drops lane 0's extra element loses a term, and that shows up as a wrong total. It checks N=1 and N=2, where an off-by-one in the stop condition would give an extra round or a missing one. It also checks counts of 0 and 15, which an unclamped design would turn into a hang or a wrong sum. Each request is tracked cycle by cycle against a latency computed from N, so a stall or an early done is visible. Further stimulus covers a start pulse and a mode flip during a busy request, an all-ones input that must wrap, and input changes after completion, which must not disturb the held result.

// File: rtl/tre_pkg.sv
package tre_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOCAL = 2'd1,
        PH_TREE  = 2'd2
    } phase_e;

    typedef struct packed {
        logic load;
        logic local_add;
        logic tree_add;
    } lane_ctl_t;

    function automatic int clamp_count(int req, int lanes);
        if (req < 1)
            return 1;
        if (req > lanes)
            return lanes;
        return req;
    endfunction

endpackage

// File: rtl/tre_round_unit.sv
module tre_round_unit #(
    parameter int LANES = 10,
    parameter int DW    = 32,
    parameter int CW    = 4
) (
    input  logic [LANES-1:0][DW-1:0] cur_i,
    input  logic [CW-1:0]            half_i,
    output logic [LANES-1:0][DW-1:0] nxt_o
);
    localparam int IW = (LANES > 1) ? $clog2(LANES) : 1;

    logic [CW-1:0] split;
    logic [DW-1:0] odd_extra;

    assign split = half_i >> 1;

    always_comb begin
        logic [IW-1:0] tail;
        tail      = IW'(half_i - CW'(1));
        odd_extra = '0;
        if (half_i[0] && half_i > CW'(1))
            odd_extra = cur_i[tail];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            logic [IW-1:0] partner;
            partner  = IW'(CW'(i) + split);
            nxt_o[i] = cur_i[i];
            if (CW'(i) < split) begin
                if (i == 0)
                    nxt_o[i] = cur_i[i] + cur_i[partner] + odd_extra;
                else
                    nxt_o[i] = cur_i[i] + cur_i[partner];
            end
        end
    end

endmodule

// File: rtl/tre_local_unit.sv
module tre_local_unit #(
    parameter int LANES = 10,
    parameter int SLICE = 4,
    parameter int DW    = 32,
    parameter int SW    = 2
) (
    input  logic [LANES*SLICE*DW-1:0] vec_i,
    input  logic [SW-1:0]             step_i,
    input  logic [LANES-1:0][DW-1:0]  cur_i,
    output logic [LANES-1:0][DW-1:0]  nxt_o
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [SLICE-1:0][DW-1:0] slice;
        assign slice    = vec_i[i*SLICE*DW +: SLICE*DW];
        assign nxt_o[i] = cur_i[i] + slice[step_i];
    end

endmodule

// File: rtl/tre_ctrl.sv
module tre_ctrl
    import tre_pkg::*;
#(
    parameter int LANES = 10,
    parameter int SLICE = 4,
    parameter int CW    = 4,
    parameter int SW    = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          local_en_i,
    input  logic [CW-1:0] count_i,
    output phase_e        phase_o,
    output logic [CW-1:0] half_o,
    output logic [SW-1:0] step_o,
    output lane_ctl_t     ctl_o,
    output logic          done_o
);
    phase_e        phase_q;
    logic [CW-1:0] half_q;
    logic [SW-1:0] step_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            half_q  <= CW'(1);
            step_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        half_q  <= CW'(clamp_count(int'(count_i), LANES));
                        step_q  <= SW'(1);
                        phase_q <= (local_en_i && SLICE > 1) ? PH_LOCAL : PH_TREE;
                    end
                end
                PH_LOCAL: begin
                    if (step_q == SW'(SLICE - 1))
                        phase_q <= PH_TREE;
                    else
                        step_q <= step_q + SW'(1);
                end
                PH_TREE: begin
                    if (half_q == CW'(1)) begin
                        done_q  <= 1'b1;
                        phase_q <= PH_IDLE;
                    end else begin
                        half_q <= half_q >> 1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl_o.load      = (phase_q == PH_IDLE) && start_i;
        ctl_o.local_add = (phase_q == PH_LOCAL);
        ctl_o.tree_add  = (phase_q == PH_TREE) && (half_q != CW'(1));
    end

    assign phase_o = phase_q;
    assign half_o  = half_q;
    assign step_o  = step_q;
    assign done_o  = done_q;

    // R6: completion is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R10: the engine is idle whenever done is shown
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_q |-> phase_q == PH_IDLE);

    // R7: a start seen mid-request neither restarts nor ends it early
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && start_i && !(phase_q == PH_TREE && half_q == CW'(1)))
        |=> phase_q != PH_IDLE && !done_q);

    // R4: the active count stays within 1..LANES during the tree
    a_r4_half_range: assert property (@(posedge clk) disable iff (rst)
        phase_q == PH_TREE |-> (half_q >= CW'(1) && half_q <= CW'(LANES)));

endmodule

// File: rtl/tree_reduce_engine.sv
module tree_reduce_engine
    import tre_pkg::*;
#(
    parameter int LANES = 10,
    parameter int SLICE = 4,
    parameter int DW    = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start_i,
    input  logic                         local_en_i,
    input  logic [$clog2(LANES+1)-1:0]   count_i,
    input  logic [LANES*SLICE*DW-1:0]    din_i,
    output logic                         busy_o,
    output logic                         done_o,
    output logic [DW-1:0]                sum_o
);
    localparam int CW = $clog2(LANES + 1);
    localparam int SW = (SLICE > 1) ? $clog2(SLICE) : 1;
    localparam int VW = LANES * SLICE * DW;

    phase_e                   phase;
    logic [CW-1:0]            half;
    logic [SW-1:0]            step;
    lane_ctl_t                ctl;
    logic [LANES-1:0][DW-1:0] acc_q;
    logic [LANES-1:0][DW-1:0] first_val;
    logic [LANES-1:0][DW-1:0] local_nxt;
    logic [LANES-1:0][DW-1:0] tree_nxt;
    logic [VW-1:0]            vec_q;

    tre_ctrl #(.LANES(LANES), .SLICE(SLICE), .CW(CW), .SW(SW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .local_en_i (local_en_i),
        .count_i    (count_i),
        .phase_o    (phase),
        .half_o     (half),
        .step_o     (step),
        .ctl_o      (ctl),
        .done_o     (done_o)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_first
        assign first_val[i] = din_i[i*SLICE*DW +: DW];
    end

    tre_local_unit #(.LANES(LANES), .SLICE(SLICE), .DW(DW), .SW(SW)) u_local (
        .vec_i  (vec_q),
        .step_i (step),
        .cur_i  (acc_q),
        .nxt_o  (local_nxt)
    );

    tre_round_unit #(.LANES(LANES), .DW(DW), .CW(CW)) u_round (
        .cur_i  (acc_q),
        .half_i (half),
        .nxt_o  (tree_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            vec_q <= '0;
        end else if (ctl.load) begin
            acc_q <= first_val;
            vec_q <= din_i;
        end else if (ctl.local_add) begin
            acc_q <= local_nxt;
        end else if (ctl.tree_add) begin
            acc_q <= tree_nxt;
        end
    end

    assign busy_o = (phase != PH_IDLE);
    assign sum_o  = acc_q[0];

    // R1: reset leaves the outputs cleared
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o && sum_o == '0));

    // R9: the result does not move while idle without a start
    a_r9_result_held: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(sum_o));

    // R10: busy and done are never high together
    a_r10_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));

endmodule

// File: tb/tb_tree_reduce_engine.sv
module tb_tree_reduce_engine;
    localparam int LANES = 10;
    localparam int SLICE = 4;
    localparam int DW    = 32;
    localparam int CW    = $clog2(LANES + 1);
    localparam int NE    = LANES * SLICE;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              local_en = 1'b0;
    logic [CW-1:0]     count = '0;
    logic [NE*DW-1:0]  din = '0;
    logic              busy, done;
    logic [DW-1:0]     sum;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    tree_reduce_engine #(.LANES(LANES), .SLICE(SLICE), .DW(DW)) dut (
        .clk(clk), .rst(rst), .start_i(start), .local_en_i(local_en),
        .count_i(count), .din_i(din), .busy_o(busy), .done_o(done), .sum_o(sum)
    );

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic fill(int seed);
        for (int k = 0; k < NE; k++)
            din[k*DW +: DW] = DW'(k * 37 + seed * 1001 + 3);
    endtask

    function automatic int clampn(int req);
        if (req < 1) return 1;
        if (req > LANES) return LANES;
        return req;
    endfunction

    function automatic logic [DW-1:0] model_sum(int n, bit loc);
        logic [DW-1:0] s = '0;
        for (int lane = 0; lane < n; lane++)
            for (int e = 0; e < (loc ? SLICE : 1); e++)
                s += din[(lane*SLICE + e)*DW +: DW];
        return s;
    endfunction

    function automatic int rounds(int n);
        int r = 0;
        while (n > 1) begin
            n = n / 2;
            r++;
        end
        return r;
    endfunction

    task automatic run(int req, bit loc, bit poke, string tag);
        int n, k;
        logic [DW-1:0] exp;
        n   = clampn(req);
        exp = model_sum(n, loc);
        k   = (loc ? SLICE - 1 : 0) + rounds(n) + 1;
        @(negedge clk);
        count = CW'(req); local_en = loc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int m = 0; m <= k; m++) begin
            if (m > 0) @(negedge clk);
            if (poke && m == 1) begin
                start = 1'b1; count = CW'(1); local_en = !loc;
            end else if (poke && m == 2) begin
                start = 1'b0;
            end
            chk(busy == (m < k), "R10", {tag, " busy"}, busy, (m < k));
            chk(done == (m == k), "R5", {tag, " done timing"}, done, (m == k));
            if (m == k)
                chk(sum == exp, tag, "total", sum, exp);
        end
        @(negedge clk);
        chk(done == 1'b0, "R6", {tag, " done pulse width"}, done, 0);
        chk(sum == exp, "R9", {tag, " held total"}, sum, exp);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R5 watchdog: got hung expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] held;
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0, "R1", "flags in reset", {busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && done == 0, "R1", "flags after reset", {busy, done}, 0);
        chk(sum == 0, "R1", "sum after reset", sum, 0);

        fill(1);
        run(10, 0, 0, "R2");
        run(10, 1, 0, "R3");
        fill(2);
        run(7, 1, 0, "R4");
        run(5, 0, 0, "R4");
        run(3, 1, 0, "R4");
        run(9, 0, 0, "R4");
        run(2, 1, 0, "R4");
        run(1, 0, 0, "R4");
        run(1, 1, 0, "R3");
        run(0, 0, 0, "R4");
        run(15, 1, 0, "R4");
        run(9, 1, 1, "R7");
        run(6, 0, 1, "R7");

        for (int k = 0; k < NE; k++)
            din[k*DW +: DW] = '1;
        run(10, 1, 0, "R8");

        held = sum;
        fill(3);
        repeat (5) @(negedge clk);
        chk(sum == held, "R9", "idle input change", sum, held);
        chk(busy == 0 && done == 0, "R10", "idle flags", {busy, done}, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule